// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns one column access request into the per-clock column addresses of a burst inside an open DRAM page. A start strobe captures a 9-bit starting column, a 3-bit length code and an ordering bit. From the next clock on, the block drives one column address per cycle with a valid flag, and it flags the final beat of a fixed-length burst. A terminate strobe cuts a running burst short. A fresh start strobe replaces any burst in progress, so a controller can issue a new column on every cycle.

Bursts of 2, 4 or 8 beats stay inside an aligned block of that size. The column bits above the block stay fixed, and the low bits either count up and wrap (sequential order) or are the start XORed with the beat index (interleaved order). A full-page burst counts up through all 512 columns, wraps at the end of the page and runs until it is terminated.

The control is a three-state machine. The states are IDLE (no burst), FIXED (a burst of 1 to 8 beats) and PAGE (an open-ended page burst). The transitions are:
- launch_fixed: IDLE, FIXED or PAGE to FIXED, on start with a non-page code.
- launch_page: IDLE, FIXED or PAGE to PAGE, on start with the page code.
- finish: FIXED to IDLE after the last beat.
- cut: FIXED or PAGE to IDLE on terminate without start.
- hold: every other case keeps the current state.

Top module: `burst_col_gen`

## Requirements
- R1: While no burst is active, valid_o, last_o and len_err_o are all low. This is also the state after reset.
- R2: A start sampled at a clock edge puts the starting column on col_o with valid_o high right after that edge. Each following edge moves to the next beat.
- R3: Length codes 000, 001, 010 and 011 give bursts of 1, 2, 4 and 8 beats. For 2, 4 and 8 beats, column bits from bit 1, 2 or 3 upward stay at the start value for the whole burst.
- R4: With order_i = 0 (sequential), the low block bits count up from the start and wrap inside the block. For example, 4 beats from 0x42 give 0x42, 0x43, 0x40, 0x41.
- R5: With order_i = 1 (interleaved), the low block bits are the start XOR the beat index. For example, 8 beats from 0x1D give 1D, 1C, 1F, 1E, 19, 18, 1B, 1A.
- R6: For length code 000, order_i has no effect and exactly the starting column is produced, with last_o high.
- R7: Length code 111 starts a full-page burst. It is always sequential (order_i is ignored), increments modulo 512 and keeps running until it is terminated.
- R8: A terminate sampled at an edge without start ends the burst. valid_o is low after that edge, for both fixed and page bursts.
- R9: A start sampled while a burst is active drops the old burst, and the new burst's first column appears right after that edge. Start takes priority over terminate.
- R10: last_o is high on the final beat of a fixed-length burst. The burst ends after that beat unless a start arrives. last_o is never high during a page burst.
- R11: Reserved length codes 100, 101 and 110 act as length 1, and len_err_o is high together with that single beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a burst using the inputs below |
| term_i | input | 1 | Truncate the running burst |
| col_start_i | input | 9 | Starting column |
| len_code_i | input | 3 | Burst length code |
| order_i | input | 1 | 0 sequential, 1 interleaved |
| col_o | output | 9 | Column address of the current beat |
| valid_o | output | 1 | col_o holds a beat |
| last_o | output | 1 | Final beat of a fixed-length burst |
| len_err_o | output | 1 | Current beat came from a reserved length code |

## Verification
The assertions assume that start_i and term_i are clean single-cycle strobes sampled at the rising edge. They also assume that col_start_i, len_code_i and order_i are stable at the edge where start_i is high, because the single-beat and reserved-code checks compare the output with their values at that edge. The bench drives every input one nanosecond after a rising edge and holds it for a full cycle. It raises start and terminate for exactly one edge. Terminate is only raised while a burst is running, so the checks never depend on inputs that change at an edge.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

    typedef enum logic [1:0] {
        BST_IDLE  = 2'd0,
        BST_FIXED = 2'd1,
        BST_PAGE  = 2'd2
    } bst_state_e;

    localparam int unsigned LEN_CODE_W = 3;

endpackage

// File: rtl/bcg_len_decode.sv
module bcg_len_decode #(
    parameter int unsigned COL_W = 9
) (
    input  logic [bcg_pkg::LEN_CODE_W-1:0] code_i,
    output logic [COL_W-1:0]               mask_o,
    output logic                           page_o,
    output logic                           rsv_o
);

    always_comb begin
        mask_o = '0;
        page_o = 1'b0;
        rsv_o  = 1'b0;
        unique case (code_i)
            3'b000: mask_o = '0;
            3'b001: mask_o = COL_W'(1);
            3'b010: mask_o = COL_W'(3);
            3'b011: mask_o = COL_W'(7);
            3'b111: begin
                mask_o = '1;
                page_o = 1'b1;
            end
            default: rsv_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/bcg_beat_fsm.sv
module bcg_beat_fsm #(
    parameter int unsigned COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             term_i,
    input  logic [COL_W-1:0] col_i,
    input  logic             order_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             page_i,
    input  logic             rsv_i,
    output logic [COL_W-1:0] base_o,
    output logic [COL_W-1:0] mask_o,
    output logic [COL_W-1:0] beat_o,
    output logic             order_o,
    output logic             valid_o,
    output logic             last_o,
    output logic             err_o
);
    import bcg_pkg::*;

    bst_state_e       state_q, state_d;
    logic [COL_W-1:0] base_q, mask_q, beat_q;
    logic             order_q, err_q;
    logic             at_end;

    assign at_end = (beat_q == mask_q);

    // next state
    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = page_i ? BST_PAGE : BST_FIXED;
        end else begin
            unique case (state_q)
                BST_IDLE:  state_d = BST_IDLE;
                BST_FIXED: if (term_i || at_end) state_d = BST_IDLE;
                BST_PAGE:  if (term_i) state_d = BST_IDLE;
                default:   state_d = BST_IDLE;
            endcase
        end
    end

    // state and burst context registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BST_IDLE;
            base_q  <= '0;
            mask_q  <= '0;
            beat_q  <= '0;
            order_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start_i) begin
                base_q  <= col_i;
                mask_q  <= mask_i;
                beat_q  <= '0;
                order_q <= order_i && !page_i;
                err_q   <= rsv_i;
            end else if (state_q != BST_IDLE) begin
                beat_q  <= beat_q + COL_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        valid_o = (state_q != BST_IDLE);
        last_o  = (state_q == BST_FIXED) && at_end;
        err_o   = err_q && valid_o;
        base_o  = base_q;
        mask_o  = mask_q;
        beat_o  = beat_q;
        order_o = order_q;
    end

endmodule

// File: rtl/bcg_col_calc.sv
module bcg_col_calc #(
    parameter int unsigned COL_W = 9
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic             order_i,
    output logic [COL_W-1:0] col_o
);

    logic [COL_W-1:0] seq_col;
    logic [COL_W-1:0] ilv_col;

    assign seq_col = base_i + beat_i;
    assign ilv_col = base_i ^ beat_i;

    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        assign col_o[b] = mask_i[b] ? (order_i ? ilv_col[b] : seq_col[b]) : base_i[b];
    end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
    parameter int unsigned COL_W = 9
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start_i,
    input  logic                           term_i,
    input  logic [COL_W-1:0]               col_start_i,
    input  logic [bcg_pkg::LEN_CODE_W-1:0] len_code_i,
    input  logic                           order_i,
    output logic [COL_W-1:0]               col_o,
    output logic                           valid_o,
    output logic                           last_o,
    output logic                           len_err_o
);

    logic [COL_W-1:0] dec_mask;
    logic             dec_page, dec_rsv;
    logic [COL_W-1:0] cur_base, cur_mask, cur_beat;
    logic             cur_order;

    bcg_len_decode #(.COL_W(COL_W)) u_dec (
        .code_i (len_code_i),
        .mask_o (dec_mask),
        .page_o (dec_page),
        .rsv_o  (dec_rsv)
    );

    bcg_beat_fsm #(.COL_W(COL_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .term_i  (term_i),
        .col_i   (col_start_i),
        .order_i (order_i),
        .mask_i  (dec_mask),
        .page_i  (dec_page),
        .rsv_i   (dec_rsv),
        .base_o  (cur_base),
        .mask_o  (cur_mask),
        .beat_o  (cur_beat),
        .order_o (cur_order),
        .valid_o (valid_o),
        .last_o  (last_o),
        .err_o   (len_err_o)
    );

    bcg_col_calc #(.COL_W(COL_W)) u_col (
        .base_i  (cur_base),
        .mask_i  (cur_mask),
        .beat_i  (cur_beat),
        .order_i (cur_order),
        .col_o   (col_o)
    );

endmodule

// File: rtl/bcg_chk.sv
module bcg_chk #(
    parameter int unsigned COL_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             term_i,
    input logic [COL_W-1:0] col_start_i,
    input logic [2:0]       len_code_i,
    input logic [COL_W-1:0] col_o,
    input logic             valid_o,
    input logic             last_o,
    input logic             len_err_o
);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (!last_o && !len_err_o));

    // R2
    start_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> valid_o);

    // R3
    burst_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o && !start_i && !term_i) |=> valid_o);

    // R6
    single_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && len_code_i == 3'b000) |=> (valid_o && last_o && col_o == $past(col_start_i)));

    // R8
    term_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (term_i && !start_i) |=> !valid_o);

    // R10
    last_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> !valid_o);

    // R11
    rsv_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && len_code_i[2] && len_code_i != 3'b111) |=> (len_err_o && last_o));

endmodule

bind burst_col_gen bcg_chk #(.COL_W(COL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .term_i      (term_i),
    .col_start_i (col_start_i),
    .len_code_i  (len_code_i),
    .col_o       (col_o),
    .valid_o     (valid_o),
    .last_o      (last_o),
    .len_err_o   (len_err_o)
);

// File: tb/tb_burst_col_gen.sv
`timescale 1ns/1ps
module tb_burst_col_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       term_i = 1'b0;
    logic [8:0] col_start_i = '0;
    logic [2:0] len_code_i = '0;
    logic       order_i = 1'b0;
    logic [8:0] col_o;
    logic       valid_o, last_o, len_err_o;

    int checks = 0;
    int failures = 0;

    typedef struct {
        int    col;
        bit    last;
        bit    err;
        string req;
    } exp_t;

    exp_t exp_q[$];

    always #2 clk = ~clk;

    burst_col_gen dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .term_i      (term_i),
        .col_start_i (col_start_i),
        .len_code_i  (len_code_i),
        .order_i     (order_i),
        .col_o       (col_o),
        .valid_o     (valid_o),
        .last_o      (last_o),
        .len_err_o   (len_err_o)
    );

    function automatic int beats_of(input int code, input int cut);
        int len;
        case (code)
            0: len = 1;
            1: len = 2;
            2: len = 4;
            3: len = 8;
            7: return cut;
            default: len = 1;
        endcase
        if (cut == 0 || cut > len) return len;
        return cut;
    endfunction

    // expected beats computed from the requirements
    task automatic push_exp(input int col, input int code, input bit ilv, input int cut, input string req);
        int  len;
        bit  page, rsv;
        int  n;
        page = (code == 7);
        rsv  = (code >= 4 && code <= 6);
        case (code)
            1: len = 2;
            2: len = 4;
            3: len = 8;
            7: len = 512;
            default: len = 1;
        endcase
        n = beats_of(code, cut);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            if (page)          e.col = (col + i) % 512;
            else if (len == 1) e.col = col;
            else if (ilv)      e.col = (col & ~(len - 1)) | ((col ^ i) & (len - 1));
            else               e.col = (col & ~(len - 1)) | (((col & (len - 1)) + i) % len);
            e.last = !page && (i == len - 1);
            e.err  = rsv;
            e.req  = req;
            exp_q.push_back(e);
        end
    endtask

    // driver: start strobe, then wait out the beats; optional terminate
    task automatic go(input int col, input int code, input bit ilv, input int cut,
                      input bit use_term, input string req);
        int n;
        n = beats_of(code, cut);
        push_exp(col, code, ilv, cut, req);
        start_i     = 1'b1;
        col_start_i = 9'(col);
        len_code_i  = 3'(code);
        order_i     = ilv;
        @(posedge clk); #1;
        start_i = 1'b0;
        for (int i = 1; i < n; i++) begin
            @(posedge clk); #1;
        end
        if (use_term) begin
            term_i = 1'b1;
            @(posedge clk); #1;
            term_i = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (valid_o) begin
                    checks++;
                    if (exp_q.size() == 0) begin
                        failures++;
                        $display("FAIL R8 unexpected beat col=%0h expected no beat", col_o);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        if (int'(col_o) != e.col || last_o != e.last || len_err_o != e.err) begin
                            failures++;
                            $display("FAIL %s col/last/err=%0h/%0b/%0b expected %0h/%0b/%0b",
                                     e.req, col_o, last_o, len_err_o, e.col, e.last, e.err);
                        end
                    end
                end else begin
                    checks++;
                    if (last_o || len_err_o) begin
                        failures++;
                        $display("FAIL R1 idle flags last/err=%0b/%0b expected 0/0", last_o, len_err_o);
                    end
                end
            end
        end
    end

    initial begin
        #(4 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        checks++;
        if (valid_o || last_o || len_err_o) begin
            failures++;
            $display("FAIL R1 reset valid/last/err=%0b/%0b/%0b expected 0/0/0", valid_o, last_o, len_err_o);
        end

        go(5, 0, 1'b1, 0, 1'b0, "R6");          // length 1, type ignored
        idle(2);
        go(9'h13, 1, 1'b0, 0, 1'b0, "R3");      // length 2
        idle(1);
        go(9'h42, 2, 1'b0, 0, 1'b0, "R4");      // 42,43,40,41
        idle(1);
        go(9'h1D, 3, 1'b1, 0, 1'b0, "R5");      // interleaved 8
        idle(1);
        go(9'h1FE, 3, 1'b0, 0, 1'b0, "R4");     // wrap within top block
        idle(1);
        go(9'h0B, 2, 1'b1, 0, 1'b0, "R5");      // interleaved 4: B,A,9,8
        idle(1);
        go(7, 4, 1'b0, 0, 1'b0, "R11");
        idle(1);
        go(9'h33, 6, 1'b1, 0, 1'b0, "R11");
        idle(1);
        go(9'h1FC, 7, 1'b1, 10, 1'b1, "R7");    // page, wraps past 1FF, type ignored
        idle(2);
        go(9'h20, 3, 1'b0, 3, 1'b1, "R8");      // fixed cut after 3
        idle(2);
        go(9'h50, 3, 1'b1, 3, 1'b0, "R9");      // restarted by next start
        go(9'h61, 2, 1'b0, 0, 1'b0, "R9");
        go(9'h80, 1, 1'b1, 0, 1'b0, "R10");     // back-to-back natural ends
        go(9'h81, 1, 1'b0, 0, 1'b0, "R10");
        go(9'h100, 7, 1'b0, 5, 1'b0, "R9");     // page replaced by start
        go(9'h07, 0, 1'b0, 0, 1'b0, "R9");
        idle(4);

        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL R2 missing beats=%0d expected 0", exp_q.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule